// File: doc/BRIEF.md
# Stream-Mode Radio Sequencer With Interrupt Status

This block is the control side of a packet radio modem running in stream mode, where payload words move between host and modem one at a time instead of through a packet memory. The host programs a small configuration word and a start bit. The sequence begins once the sequence-enable input is high. If that input is tied high, the start bit alone launches the sequence. The block then sits in a receive or transmit state until the datapath signals end of frame or the host drops the enable.

Completion, CRC result and stream faults are collected in a status register that is cleared when it is read. A mask register gates each status bit onto a single interrupt line. The link quality of each received frame is held in a latch register. After a sequence ends, a stream fault can still be reported during a tick-counted grace window, while the out-of-idle pin is already low.

Top module: `radio_seq_irq`

## Requirements
- R1: After reset the status register, the link-quality latch and the mask register are zero, the sequencer is idle, and out_of_idle, crc_valid, irq and data_ready are low.
- R2: A control write (ctl_we) with ctl_cfg bit 0 (start) set, bit 2 (stream) set and bit 1 (timer trigger) clear starts transmit when bits 4:3 are 00 and receive when they are 10. The sequence begins at that edge if seq_en is high, or otherwise at the first edge where seq_en is high. Any other configuration, or a start while a sequence is running, has no effect.
- R3: out_of_idle is high exactly while a receive or transmit sequence is running. It goes high in the cycle after the starting edge.
- R4: frm_end during receive ends the sequence and sets status bit 13. It copies crc_ok into status bit 0 and latches lqi_in into bits 15:8 of lqi_q, with bits 7:0 held at zero. The crc_valid pin always equals status bit 0.
- R5: frm_end during transmit ends the sequence and sets status bit 14.
- R6: seq_en low during receive aborts it: the next cycle the block is idle, bit 13 is set and bit 0 is not set. seq_en low during transmit aborts it and sets bit 14.
- R7: stat_rd clears every status bit at the next edge. A bit set by an event at that same edge stays set.
- R8: irq is high exactly when some status bit is set and its mask bit is clear. mask_we loads mask_in into the mask register.
- R9: During receive, word_rx raises data_ready and word_rd lowers it. A word_rx while data_ready is high and word_rd is low sets status bit 5. strm_fault during any running sequence also sets bit 5.
- R10: After a sequence ends, strm_fault still sets bit 5 until LATE_TICKS (64) tick_us pulses have passed. After that, a strm_fault in idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seq_en | input | 1 | Sequence enable; low aborts a running sequence |
| ctl_we | input | 1 | Control write strobe |
| ctl_cfg | input | 5 | {mode[1:0], stream, timer_trig, start} |
| mask_we | input | 1 | Mask register write strobe |
| mask_in | input | 16 | Mask value, 1 masks that status bit |
| stat_rd | input | 1 | Status read strobe, clears on next edge |
| frm_end | input | 1 | End-of-frame event from datapath |
| crc_ok | input | 1 | CRC result accompanying frm_end |
| lqi_in | input | 8 | Link quality accompanying frm_end |
| word_rx | input | 1 | Stream receive word arrived |
| word_rd | input | 1 | Host has read the stream word |
| strm_fault | input | 1 | Stream underrun/overrun from datapath |
| tick_us | input | 1 | Microsecond tick for the late window |
| stat_q | output | 16 | Interrupt status register |
| lqi_q | output | 16 | Receive latch, link quality in bits 15:8 |
| out_of_idle | output | 1 | High while a sequence runs |
| crc_valid | output | 1 | Mirror of status bit 0 |
| irq | output | 1 | Interrupt request |
| data_ready | output | 1 | Stream receive word waiting |

## Verification
A wrong sequencer state shows one cycle later on out_of_idle, and at the end of the frame as a missing or extra done bit in the status. A late-window counter that is off by one only shows at its boundary. There, a strm_fault at the 63rd or 64th tick after an abort either sets bit 5 or leaves it clear, and that result shows the next cycle. Masking and read-clear errors appear on irq in the cycle after the mask write or the read.

// File: rtl/radio_seq_irq.sv
module radio_seq_irq #(
  parameter int STAT_W     = 16,
  parameter int LQI_W      = 8,
  parameter int LATE_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_en,
  input  logic              ctl_we,
  input  logic [4:0]        ctl_cfg,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_in,
  input  logic              stat_rd,
  input  logic              frm_end,
  input  logic              crc_ok,
  input  logic [LQI_W-1:0]  lqi_in,
  input  logic              word_rx,
  input  logic              word_rd,
  input  logic              strm_fault,
  input  logic              tick_us,
  output logic [STAT_W-1:0] stat_q,
  output logic [2*LQI_W-1:0] lqi_q,
  output logic              out_of_idle,
  output logic              crc_valid,
  output logic              irq,
  output logic              data_ready
);
  localparam int CNT_W = $clog2(LATE_TICKS + 1);
  localparam int B_CRC = 0;
  localparam int B_ERR = 5;
  localparam int B_RXD = 13;
  localparam int B_TXD = 14;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_TX} st_t;

  st_t               st, st_n;
  logic              pend, pend_rx;
  logic [STAT_W-1:0] mask, set_vec;
  logic [CNT_W-1:0]  win_cnt;

  wire cfg_ok  = ctl_cfg[2] & ~ctl_cfg[1] & (ctl_cfg[3] == 1'b0);
  wire go_req  = ctl_we & ctl_cfg[0] & cfg_ok & (st == S_IDLE);
  wire start   = seq_en & (go_req | pend);
  wire start_rx = go_req ? ctl_cfg[4] : pend_rx;
  wire rx_end  = (st == S_RX) & (~seq_en | frm_end);
  wire tx_end  = (st == S_TX) & (~seq_en | frm_end);
  wire rx_good = (st == S_RX) & seq_en & frm_end;
  wire overrun = (st == S_RX) & word_rx & data_ready & ~word_rd;
  wire late_ok = (st != S_IDLE) | (win_cnt != '0);

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (start) st_n = start_rx ? S_RX : S_TX;
      default: if (~seq_en | frm_end) st_n = S_IDLE;
    endcase
  end

  always_comb begin
    set_vec        = '0;
    set_vec[B_CRC] = rx_good & crc_ok;
    set_vec[B_ERR] = overrun | (strm_fault & late_ok);
    set_vec[B_RXD] = rx_end;
    set_vec[B_TXD] = tx_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pend       <= 1'b0;
      pend_rx    <= 1'b0;
      stat_q     <= '0;
      mask       <= '0;
      lqi_q      <= '0;
      data_ready <= 1'b0;
      win_cnt    <= '0;
    end else begin
      st <= st_n;
      if (start) pend <= 1'b0;
      else if (go_req) begin
        pend    <= 1'b1;
        pend_rx <= ctl_cfg[4];
      end
      stat_q <= (stat_rd ? '0 : stat_q) | set_vec;
      if (mask_we) mask <= mask_in;
      if (rx_good) lqi_q <= {lqi_in, {LQI_W{1'b0}}};
      if (st == S_IDLE && start) data_ready <= 1'b0;
      else if (st == S_RX && word_rx) data_ready <= 1'b1;
      else if (word_rd) data_ready <= 1'b0;
      if (st != S_IDLE && st_n == S_IDLE) win_cnt <= CNT_W'(LATE_TICKS);
      else if (st != S_IDLE) win_cnt <= '0;
      else if (tick_us && win_cnt != '0) win_cnt <= win_cnt - 1'b1;
    end
  end

  assign out_of_idle = (st != S_IDLE);
  assign crc_valid   = stat_q[B_CRC];
  assign irq         = |(stat_q & ~mask);

  // R6
  rx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && !seq_en) |=> (st == S_IDLE && stat_q[B_RXD] && !stat_q[B_CRC]));
  // R2
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_of_idle) |-> $past(seq_en));
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && set_vec == '0) |=> !irq);
  // R10
  late_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[B_ERR]) |-> ($past(st) != S_IDLE || $past(win_cnt) != '0));
  // R4
  lqi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_good |=> $stable(lqi_q));
endmodule

// File: tb/test_radio_seq_irq.sv
module test_radio_seq_irq;
  localparam int CLK = 10;
  logic clk = 0, rst_n = 0;
  logic seq_en = 0, ctl_we = 0, mask_we = 0, stat_rd = 0, frm_end = 0, crc_ok = 0;
  logic word_rx = 0, word_rd = 0, strm_fault = 0, tick_us = 0;
  logic [4:0] ctl_cfg = 0;
  logic [15:0] mask_in = 0, stat_q, lqi_q;
  logic [7:0] lqi_in = 0;
  logic out_of_idle, crc_valid, irq, data_ready;
  int errs = 0, checks = 0;

  always #(CLK/2) clk = ~clk;

  radio_seq_irq i_radio_seq_irq (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic start(logic [1:0] mode);
    ctl_we = 1; ctl_cfg = {mode, 3'b101}; cyc(); ctl_we = 0; ctl_cfg = 0;
  endtask

  task automatic end_frame(logic c, logic [7:0] q);
    frm_end = 1; crc_ok = c; lqi_in = q; cyc(); frm_end = 0; crc_ok = 0;
  endtask

  task automatic rd(); stat_rd = 1; cyc(); stat_rd = 0; endtask

  initial begin
    #(CLK*200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    // R1
    chk("R1 status", stat_q, 0);
    chk("R1 pins", {out_of_idle, crc_valid, irq, data_ready, lqi_q}, 0);

    // R4 R8 R7 sweep
    seq_en = 1;
    for (int c = 0; c < 2; c++)
      for (int li = 0; li < 4; li++)
        for (int m = 0; m < 2; m++) begin
          mask_we = 1; mask_in = 16'(m) << 13; cyc(); mask_we = 0;
          start(2'b10);
          chk("R3 rx running", out_of_idle, 1);
          end_frame(c[0], 8'(li*85));
          chk("R4 status", stat_q, 32'h2000 | c);
          chk("R4 lqi", lqi_q, (li*85) << 8);
          chk("R4 crc pin", crc_valid, c);
          chk("R3 idle", out_of_idle, 0);
          chk("R8 irq", irq, c[0] | (m == 0));
          rd();
          chk("R7 cleared", {irq, stat_q}, 0);
        end
    mask_we = 1; mask_in = 0; cyc(); mask_we = 0;

    // R2 invalid configs
    ctl_we = 1; ctl_cfg = 5'b10111; cyc(); ctl_we = 0; cyc();
    chk("R2 timer cfg ignored", out_of_idle, 0);
    ctl_we = 1; ctl_cfg = 5'b01101; cyc(); ctl_we = 0; cyc();
    chk("R2 mode 01 ignored", out_of_idle, 0);
    ctl_we = 1; ctl_cfg = 5'b00001; cyc(); ctl_we = 0; cyc();
    chk("R2 no stream ignored", out_of_idle, 0);

    // R2 pending start, R5 transmit
    seq_en = 0; start(2'b00); cyc();
    chk("R2 waits enable", out_of_idle, 0);
    seq_en = 1; cyc();
    chk("R2 starts on enable", out_of_idle, 1);
    start(2'b10); end_frame(0, 8'h33);
    chk("R5 tx done", stat_q, 16'h4000);
    chk("R2 restart ignored", lqi_q, 16'hFF00);
    rd();

    // R9 stream receive
    start(2'b10);
    word_rx = 1; cyc(); word_rx = 0;
    chk("R9 ready", data_ready, 1);
    word_rd = 1; cyc(); word_rd = 0;
    chk("R9 read lowers", {data_ready, stat_q}, 0);
    word_rx = 1; cyc(); word_rx = 1; cyc(); word_rx = 0;
    chk("R9 overrun", stat_q, 16'h0020);
    rd();
    strm_fault = 1; cyc(); strm_fault = 0;
    chk("R9 fault active", stat_q, 16'h0020);
    rd();

    // R6 abort + R10 late window
    seq_en = 0; cyc();
    chk("R6 abort", {out_of_idle, stat_q}, 17'h02000);
    rd();
    seq_en = 1;
    for (int k = 0; k < 63; k++) begin tick_us = 1; cyc(); tick_us = 0; end
    strm_fault = 1; cyc(); strm_fault = 0;
    chk("R10 late fault", {out_of_idle, stat_q}, 17'h00020);
    rd();
    tick_us = 1; cyc(); tick_us = 0;
    strm_fault = 1; cyc(); strm_fault = 0; cyc();
    chk("R10 after window", {irq, stat_q}, 0);

    // R6 tx abort, R7 set wins over read
    start(2'b00); seq_en = 0; stat_rd = 1; cyc(); stat_rd = 0;
    chk("R7 set wins", stat_q, 16'h4000);
    chk("R6 tx abort", out_of_idle, 0);
    // R8 full mask
    mask_we = 1; mask_in = 16'hFFFF; cyc(); mask_we = 0;
    chk("R8 masked", irq, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule